// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Quad 12-Bit Converter

This block is the serial control front end of a four-channel, 12-bit voltage-output converter. A system clock oversamples the two bus lines, SCL and SDA. The block detects START, repeated START and STOP conditions and shifts in 8-bit words. It acknowledges by asserting an open-drain pull-down enable on SDA. The device address is a 7-bit parameter.

A write frame is one address byte followed by any number of byte pairs. Each pair updates one channel's 12-bit code and its 2-bit power-down mode. The code and mode registers drive the analog side directly as flat output vectors.

The slave goes deaf to the bus after a STOP, after a wrong address, or after a read request, and stays so until the next START. A STOP that lands in the same SCL high pulse as its START is treated as illegal and ignored. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_dac_slave`

## Requirements
- R1: After reset every channel code is 0, every channel mode is 2'b01 (floating output), and `sda_oe_o` is low.
- R2: An address byte whose upper 7 bits equal `DEV_ADDR` and whose bit 0 is 0 is acknowledged. `sda_oe_o` is high during the high phase of the ninth SCL pulse and low again once that pulse has ended.
- R3: An address byte with a different address is not acknowledged. All later bytes get no acknowledge and change no register until a new START.
- R4: After a STOP, bytes clocked without a new START get no acknowledge and change no register.
- R5: After the address, bytes form pairs. In the first byte, bits 7:6 select the channel, bits 5:4 carry the mode and bits 3:0 carry code bits 11:8. The second byte carries code bits 7:0. Every data byte of an addressed frame is acknowledged, and a channel is updated only when the second byte of its pair is acknowledged.
- R6: A STOP at any bit position aborts the current pair without changing any register. The next frame starts with a fresh first byte.
- R7: A STOP inside the same SCL high pulse as the START is ignored. The slave stays addressed and expects an address byte.
- R8: A repeated START returns the slave to the address phase without a STOP. Several pairs may follow one address.
- R9: Mode codes are 00 active, 01 floating, 10 1 kΩ to ground and 11 100 kΩ to ground. A pair with a nonzero mode sets the mode and leaves the stored code unchanged. A pair with mode 00 sets the mode and loads the new code.
- R10: An address byte with the correct address and bit 0 set to 1 (read) is not acknowledged. The slave then ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| code_o | output | NCH*DW (48) | Channel codes, channel n at bits n*DW +: DW |
| pd_mode_o | output | 2*NCH (8) | Mode per channel, channel n at bits 2n +: 2 |

## Verification
A wrong lock or address state shows up within one byte: the acknowledge appears, or fails to appear, in the ninth SCL high phase of the very next byte. A misaligned pair pointer shows as a corrupted code or a wrong channel. Every pair written in this state lands on the wrong register, so the corruption is visible on `code_o` and `pd_mode_o` a few system clocks after the second byte's acknowledge. The bench drives frames through both lines and models the wired SDA. It compares acknowledges and all four channels against a model kept from the requirements, after every frame.

// File: rtl/dac_slave_pkg.sv
package dac_slave_pkg;
  typedef enum logic [1:0] {
    PD_ACTIVE    = 2'b00,
    PD_FLOAT     = 2'b01,
    PD_LOAD_1K   = 2'b10,
    PD_LOAD_100K = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/dac_line_sync.sv
module dac_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_s      = sda_sh[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dac_byte_rx.sv
module dac_byte_rx #(
  parameter int            BW       = 8,
  parameter logic [BW-2:0] DEV_ADDR = 7'h3A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          sda_oe_o,
  output logic          byte_stb_o,
  output logic [BW-1:0] byte_o,
  output logic          frame_rst_o
);
  localparam int CNT_W = $clog2(BW + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BW);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BW + 1);

  logic             active_q, addr_ph_q, start_hi_q, oe_q, stb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    sh_q;
  logic             stop_ok, addr_ok;

  // a STOP in the START's own high pulse is illegal and dropped
  assign stop_ok = stop_i & ~start_hi_q;
  assign addr_ok = (sh_q[BW-1:1] == DEV_ADDR) & ~sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      addr_ph_q  <= 1'b0;
      start_hi_q <= 1'b0;
      oe_q       <= 1'b0;
      stb_q      <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start_i) begin
        active_q   <= 1'b1;
        addr_ph_q  <= 1'b1;
        start_hi_q <= 1'b1;
        oe_q       <= 1'b0;
        cnt_q      <= '0;
      end else if (stop_ok) begin
        active_q   <= 1'b0;
        start_hi_q <= 1'b0;
        oe_q       <= 1'b0;
        cnt_q      <= '0;
      end else begin
        if (scl_fall_i) start_hi_q <= 1'b0;
        if (active_q) begin
          if (scl_rise_i && cnt_q != ACK_DONE) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q < ACK_SLOT) sh_q <= {sh_q[BW-2:0], sda_i};
          end
          if (scl_fall_i && cnt_q == ACK_SLOT) begin
            if (addr_ph_q) begin
              if (addr_ok) oe_q <= 1'b1;
              else begin
                active_q <= 1'b0;
                cnt_q    <= '0;
              end
            end else begin
              oe_q  <= 1'b1;
              stb_q <= 1'b1;
            end
          end
          if (scl_fall_i && cnt_q == ACK_DONE) begin
            oe_q      <= 1'b0;
            cnt_q     <= '0;
            addr_ph_q <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign byte_stb_o  = stb_q;
  assign byte_o      = sh_q;
  assign frame_rst_o = start_i | stop_ok;

  // R7
  start_hi_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_hi_q |-> active_q);
  // R3 R4
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sda_oe_o);
  // R2
  ack_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));
  // R5
  stb_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |-> sda_oe_o);
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_slave_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter int BW  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_stb_i,
  input  logic [BW-1:0]           byte_i,
  input  logic                    frame_rst_i,
  output logic [NCH*DW-1:0]       code_o,
  output logic [2*NCH-1:0]        pd_mode_o
);
  localparam int SEL_W = $clog2(NCH);
  localparam int HI_W  = DW - BW;

  logic                     half_q;
  logic [SEL_W-1:0]         hold_sel_q;
  pd_mode_e                 hold_pd_q;
  logic [HI_W-1:0]          hold_hi_q;
  logic [NCH-1:0][DW-1:0]   code_q;
  pd_mode_e                 pd_q [NCH];
  logic                     commit;

  assign commit = byte_stb_i & half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q     <= 1'b0;
      hold_sel_q <= '0;
      hold_pd_q  <= PD_FLOAT;
      hold_hi_q  <= '0;
    end else if (frame_rst_i) begin
      half_q <= 1'b0;
    end else if (byte_stb_i) begin
      half_q <= ~half_q;
      if (!half_q) begin
        hold_sel_q <= byte_i[BW-1 -: SEL_W];
        hold_pd_q  <= pd_mode_e'(byte_i[HI_W+1 -: 2]);
        hold_hi_q  <= byte_i[HI_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[g] <= '0;
        pd_q[g]   <= PD_FLOAT;
      end else if (commit && !frame_rst_i && hold_sel_q == SEL_W'(g)) begin
        pd_q[g] <= hold_pd_q;
        // powered-down channels keep their code for the next power-up
        if (hold_pd_q == PD_ACTIVE) code_q[g] <= {hold_hi_q, byte_i};
      end
    end
    assign pd_mode_o[2*g +: 2] = pd_q[g];
  end

  assign code_o = code_q;

  // R9
  pd_keeps_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && half_q && hold_pd_q != PD_ACTIVE) |=> $stable(code_q));
  // R5
  code_on_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> $past(byte_stb_i && half_q));
  // R6
  frame_rst_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rst_i |=> !half_q);
endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave #(
  parameter int         NCH      = 4,
  parameter int         DW       = 12,
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         SYNC     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NCH*DW-1:0] code_o,
  output logic [2*NCH-1:0]  pd_mode_o
);
  localparam int BW = 8;

  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic byte_stb, frame_rst;
  logic [BW-1:0] byte_d;

  dac_line_sync #(.STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  dac_byte_rx #(.BW(BW), .DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start_c), .stop_i(stop_c),
    .sda_oe_o, .byte_stb_o(byte_stb), .byte_o(byte_d), .frame_rst_o(frame_rst)
  );

  dac_chan_regs #(.NCH(NCH), .DW(DW), .BW(BW)) u_regs (
    .clk_i, .rst_ni,
    .byte_stb_i(byte_stb), .byte_i(byte_d), .frame_rst_i(frame_rst),
    .code_o, .pd_mode_o
  );
endmodule

// File: tb/i2c_dac_slave_test.sv
module i2c_dac_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;
  localparam logic [6:0] ADDR = 7'h3A;
  localparam logic [7:0] AW = {ADDR, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] code;
  logic [7:0]  pd;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  logic [11:0] exp_code [4];
  logic [1:0]  exp_pd [4];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dac_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .code_o(code), .pd_mode_o(pd)
  );

  task automatic hold(int n = HOLD);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, code[c*12 +: 12], exp_code[c]);
      chk(req, pd[c*2 +: 2], exp_pd[c]);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl = 1'b1;   hold();
    sda_m = 1'b0; hold();
    scl = 1'b0;   hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl = 1'b1;   hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold();
      scl = 1'b1;   hold();
      scl = 1'b0;   hold();
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hold();
    scl = 1'b1;   hold(HOLD/2);
    ack = sda_oe;
    hold(HOLD - HOLD/2);
    scl = 1'b0;   hold();
  endtask

  task automatic write_pair(int ch, logic [1:0] m, logic [11:0] v, logic exp_ack, string req);
    logic a;
    send_byte({ch[1:0], m, v[11:8]}, a); chk(req, a, exp_ack);
    send_byte(v[7:0], a);                chk(req, a, exp_ack);
    if (exp_ack) begin
      exp_pd[ch] = m;
      if (m == 2'b00) exp_code[ch] = v;
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < 4; c++) begin exp_code[c] = '0; exp_pd[c] = 2'b01; end
    chk_regs("R1");
    chk("R1", sda_oe, 0);
  endtask

  task automatic t_write_pair();
    logic a;
    bus_start();
    send_byte(AW, a); chk("R2 ack", a, 1);
    chk("R2 release", sda_oe, 0);
    write_pair(2, 2'b00, 12'hABC, 1, "R5");
    bus_stop(); hold();
    chk_regs("R5");
  endtask

  task automatic t_multi_sr();
    logic a;
    bus_start();
    send_byte(AW, a); chk("R8", a, 1);
    write_pair(0, 2'b00, 12'h123, 1, "R8");
    write_pair(1, 2'b00, 12'h456, 1, "R8");
    bus_start();
    send_byte(AW, a); chk("R8 sr addr", a, 1);
    write_pair(3, 2'b00, 12'h789, 1, "R8");
    bus_stop(); hold();
    chk_regs("R8");
  endtask

  task automatic t_powerdown();
    logic a;
    bus_start();
    send_byte(AW, a); chk("R9", a, 1);
    write_pair(2, 2'b10, 12'hFFF, 1, "R9");
    hold(); chk_regs("R9 mode10");
    write_pair(2, 2'b11, 12'h000, 1, "R9");
    hold(); chk_regs("R9 mode11");
    write_pair(2, 2'b00, 12'h5A5, 1, "R9");
    bus_stop(); hold();
    chk_regs("R9 mode00");
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte({7'h3B, 1'b0}, a); chk("R3 addr", a, 0);
    write_pair(0, 2'b00, 12'hFFF, 0, "R3");
    send_byte(AW, a); chk("R3 still locked", a, 0);
    bus_stop(); hold();
    chk_regs("R3");
  endtask

  task automatic t_read_bit();
    logic a;
    bus_start();
    send_byte({ADDR, 1'b1}, a); chk("R10 addr", a, 0);
    write_pair(1, 2'b00, 12'hEEE, 0, "R10");
    bus_stop(); hold();
    chk_regs("R10");
  endtask

  task automatic t_stop_lock();
    logic a;
    bus_start();
    send_byte(AW, a); chk("R4", a, 1);
    write_pair(1, 2'b01, 12'h000, 1, "R4");
    bus_stop();
    scl = 1'b0; hold();
    send_byte(AW, a); chk("R4 no start", a, 0);
    write_pair(1, 2'b00, 12'h000, 0, "R4");
    bus_stop(); hold();
    chk_regs("R4");
  endtask

  task automatic t_early_stop();
    logic a;
    bus_start();
    send_byte(AW, a); chk("R6", a, 1);
    send_byte({2'd0, 2'b00, 4'hE}, a); chk("R6 first", a, 1);
    bus_stop(); hold();
    chk_regs("R6 after half pair");
    bus_start();
    send_byte(AW, a); chk("R6", a, 1);
    send_bits(8'h55, 5);
    bus_stop(); hold();
    chk_regs("R6 mid byte");
    bus_start();
    send_byte(AW, a); chk("R6", a, 1);
    write_pair(0, 2'b00, 12'h321, 1, "R6 fresh pair");
    bus_stop(); hold();
    chk_regs("R6 fresh pair");
  endtask

  task automatic t_illegal_stop();
    logic a;
    sda_m = 1'b1; hold();
    scl = 1'b1;   hold();
    sda_m = 1'b0; hold();
    sda_m = 1'b1; hold();
    scl = 1'b0;   hold();
    send_byte(AW, a); chk("R7 still addressed", a, 1);
    write_pair(3, 2'b00, 12'hDEF, 1, "R7");
    bus_stop(); hold();
    chk_regs("R7");
  endtask

  initial begin
    hold(4);
    rst_n = 1'b1;
    hold(4);
    t_reset();
    t_write_pair();
    t_multi_sr();
    t_powerdown();
    t_bad_addr();
    t_read_bit();
    t_stop_lock();
    t_early_stop();
    t_illegal_stop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule